// File: doc/BRIEF.md
# Watchdog Register Front End with Magic-Sequence Unlock

This block sits between a simple register bus and the countdown core of a two-stage watchdog. It serves two access ports. A 16-byte memory window carries the two timeout preloads and a reload/status word. A small configuration port carries a mode register and a lock register. The block decodes both ports and keeps the software-visible control state. It drives the core with held levels (preloads, enable, free-run, scale select, interrupt type, reboot enable) and with single-cycle strobes (ping and flag clear). The core reports a watchdog-caused reboot through one event input, and that event sets a sticky flag that software reads back.

Writes that change preloads or reload the watchdog are guarded. Software must first write the magic value 0x80 and then 0x86 to offset 0xC. Only the next 16- or 32-bit write is then applied, after which the guard closes again. The lock bit in the configuration port can be set once and freezes the enable and free-run bits until reset. Reads on either port return data one cycle after the read strobe.

Top module: `wdt_regfront`

## Requirements
- R1: After reset the preloads are 0xFFFFF, enable, free-run, lock, fast-scale, interrupt type (0) and the reboot flag are clear, reboot is enabled, and ping/flag_clr are low.
- R2: A memory write of value 0x80 to offset 0xC followed by one of 0x86 to offset 0xC opens the guard. A 0x86 write with no 0x80 immediately before it does not open the guard.
- R3: An open guard is used up by exactly one 16- or 32-bit write, whatever that write does. A second protected write without a new sequence has no effect.
- R4: With the guard open, a 32-bit write at offset 0x0 loads preload1 from data[19:0], and one at offset 0x4 loads preload2 from data[19:0].
- R5: With the guard open, a 16-bit write at offset 0xC that has bit 8 set raises ping.
- R6: The core event input sets the reboot flag. A guarded 16-bit write at 0xC with bit 9 or bit 12 set clears it and raises flag_clr. A 16-bit read of 0xC returns 0x1200 while the flag is set and 0 otherwise.
- R7: Byte writes to the memory window never change preloads, ping or the flag. A non-magic byte write leaves the guard state as it was.
- R8: A 16- or 32-bit non-magic write while the guard is not open is ignored and returns the sequence to idle, so a later 0x86 does not open the guard.
- R9: A byte write to config address 0x68 sets lock (bit0), enable (bit1) and free-run (bit2), and reads return them in those bits. Once lock is set, writes to 0x68 are ignored until reset.
- R10: A 16-bit write to config address 0x60 sets reboot-disable (bit5, active high), fast-scale (bit2) and interrupt type (bits 1:0). Reads return the same encoding, and reboot_en is the inverse of bit5.
- R11: Read data appears the cycle after a read strobe and is 0 otherwise. Accesses of the wrong size or to an unmapped address have no effect and read as 0.
- R12: ping and flag_clr are each high for exactly one clock per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config port write strobe |
| cfg_rd | input | 1 | Config port read strobe |
| cfg_addr | input | 8 | Config port byte address |
| cfg_size | input | 3 | Access size in bytes (1, 2, 4) |
| cfg_wdata | input | 16 | Config write data |
| cfg_rdata | output | 16 | Config read data, one cycle after cfg_rd |
| mem_wr | input | 1 | Memory window write strobe |
| mem_rd | input | 1 | Memory window read strobe |
| mem_addr | input | 4 | Memory window byte offset |
| mem_size | input | 3 | Access size in bytes (1, 2, 4) |
| mem_wdata | input | 32 | Memory write data |
| mem_rdata | output | 32 | Memory read data, one cycle after mem_rd |
| core_reboot_evt | input | 1 | Core signals a watchdog-caused reboot |
| preload1 | output | 20 | First-stage timeout preload |
| preload2 | output | 20 | Second-stage timeout preload |
| wd_enable | output | 1 | Countdown enable |
| free_run | output | 1 | Restart stage one after stage-two expiry |
| fast_scale | output | 1 | Fast decrement rate select |
| irq_type | output | 2 | First-stage interrupt type |
| reboot_en | output | 1 | Reboot on second-stage expiry |
| ping | output | 1 | One-cycle keep-alive strobe |
| flag_clr | output | 1 | One-cycle reboot-flag clear strobe |

## Verification
The bench targets the guard sequence: a lone 0x86, a 0x80 broken by another write before the 0x86, and a second protected write after one write has used up the guard. A design that misses these would let stray writes reload the watchdog. Byte writes are mixed into an open sequence, because a design that treats them as full writes would either change a preload or close the guard early. The lock test writes 0x68 again after locking; a faulty design would let software turn the watchdog off. The reboot flag is set, read at both widths, and cleared through each of its two clear bits. A design that decodes only one clear bit, or that leaves the strobes high for longer than a cycle, fails these checks.

// File: rtl/wdt_regs_pkg.sv
package wdt_regs_pkg;
  localparam int PRELOAD_W = 20;
  localparam int MEM_AW    = 4;
  localparam int MEM_DW    = 32;
  localparam int CFG_AW    = 8;
  localparam int CFG_DW    = 16;

  localparam logic [MEM_AW-1:0] OFS_PRE1   = 4'h0;
  localparam logic [MEM_AW-1:0] OFS_PRE2   = 4'h4;
  localparam logic [MEM_AW-1:0] OFS_RELOAD = 4'hC;

  localparam logic [CFG_AW-1:0] CFG_MODE = 8'h60;
  localparam logic [CFG_AW-1:0] CFG_LOCK = 8'h68;

  localparam logic [MEM_DW-1:0] MAGIC_A = 32'h80;
  localparam logic [MEM_DW-1:0] MAGIC_B = 32'h86;

  localparam logic [PRELOAD_W-1:0] PRELOAD_RST = '1;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_HALF = 2'd1,
    GS_OPEN = 2'd2
  } guard_e;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [MEM_DW-1:0] mask_by_size(input logic [2:0] sz,
                                                     input logic [MEM_DW-1:0] d);
    logic [MEM_DW-1:0] r;
    case (sz)
      3'd1:    r = {{(MEM_DW-8){1'b0}}, d[7:0]};
      3'd2:    r = {{(MEM_DW-16){1'b0}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wdt_guard_seq.sv
module wdt_guard_seq
  import wdt_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MEM_AW-1:0] addr,
  input  logic [2:0]        size,
  input  logic [MEM_DW-1:0] wdata,
  output logic              grant
);
  guard_e state_q, state_d;
  logic [MEM_DW-1:0] val;
  logic at_reload, hit_a, hit_b, other, is_byte, live;

  always_comb begin
    live      = wr && size_ok(size);
    val       = mask_by_size(size, wdata);
    at_reload = (addr == OFS_RELOAD);
    is_byte   = (size == 3'd1);
    hit_a     = live && at_reload && (val == MAGIC_A);
    hit_b     = live && at_reload && (val == MAGIC_B) && (state_q == GS_HALF);
    other     = live && !hit_a && !hit_b;
    grant     = other && !is_byte && (state_q == GS_OPEN);
    state_d   = state_q;
    if (hit_a)                  state_d = GS_HALF;
    else if (hit_b)             state_d = GS_OPEN;
    else if (other && !is_byte) state_d = GS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdt_mem_regs.sv
module wdt_mem_regs
  import wdt_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant,
  input  logic                 rd,
  input  logic [MEM_AW-1:0]    addr,
  input  logic [2:0]           size,
  input  logic [MEM_DW-1:0]    wdata,
  input  logic                 reboot_evt,
  output logic [PRELOAD_W-1:0] preload1,
  output logic [PRELOAD_W-1:0] preload2,
  output logic                 ping,
  output logic                 flag_clr,
  output logic [MEM_DW-1:0]    rdata
);
  logic [PRELOAD_W-1:0] pre1_q, pre1_d, pre2_q, pre2_d;
  logic ping_q, ping_d, clr_q, clr_d, flag_q, flag_d;
  logic [MEM_DW-1:0] rdata_q, rdata_d;
  logic ld1, ld2, reload;

  always_comb begin
    ld1    = grant && (size == 3'd4) && (addr == OFS_PRE1);
    ld2    = grant && (size == 3'd4) && (addr == OFS_PRE2);
    reload = grant && (size == 3'd2) && (addr == OFS_RELOAD);
    pre1_d = ld1 ? wdata[PRELOAD_W-1:0] : pre1_q;
    pre2_d = ld2 ? wdata[PRELOAD_W-1:0] : pre2_q;
    ping_d = reload && wdata[8];
    clr_d  = reload && (wdata[9] || wdata[12]);
    flag_d = flag_q;
    if (reboot_evt) flag_d = 1'b1;
    else if (clr_d) flag_d = 1'b0;
    rdata_d = '0;
    if (rd && (size == 3'd2) && (addr == OFS_RELOAD)) begin
      rdata_d[9]  = flag_q;
      rdata_d[12] = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q  <= PRELOAD_RST;
      pre2_q  <= PRELOAD_RST;
      ping_q  <= 1'b0;
      clr_q   <= 1'b0;
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ld1) pre1_q <= pre1_d;
      if (ld2) pre2_q <= pre2_d;
      ping_q  <= ping_d;
      clr_q   <= clr_d;
      flag_q  <= flag_d;
      rdata_q <= rdata_d;
    end
  end

  assign preload1 = pre1_q;
  assign preload2 = pre2_q;
  assign ping     = ping_q;
  assign flag_clr = clr_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [CFG_AW-1:0] addr,
  input  logic [2:0]        size,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output logic              locked,
  output logic              enable,
  output logic              free_run,
  output logic              fast_scale,
  output logic [1:0]        irq_type,
  output logic              reboot_dis
);
  logic lock_q, en_q, fr_q, fs_q, rbd_q;
  logic [1:0] it_q;
  logic mode_we, lock_we;
  logic [CFG_DW-1:0] rdata_q, rdata_d;

  always_comb begin
    mode_we = wr && (addr == CFG_MODE) && (size == 3'd2);
    lock_we = wr && (addr == CFG_LOCK) && (size == 3'd1) && !lock_q;
    rdata_d = '0;
    if (rd && (addr == CFG_MODE) && (size == 3'd2)) begin
      rdata_d[5]   = rbd_q;
      rdata_d[2]   = fs_q;
      rdata_d[1:0] = it_q;
    end else if (rd && (addr == CFG_LOCK) && (size == 3'd1)) begin
      rdata_d[0] = lock_q;
      rdata_d[1] = en_q;
      rdata_d[2] = fr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      fr_q    <= 1'b0;
      fs_q    <= 1'b0;
      rbd_q   <= 1'b0;
      it_q    <= 2'd0;
      rdata_q <= '0;
    end else begin
      if (lock_we) begin
        lock_q <= wdata[0];
        en_q   <= wdata[1];
        fr_q   <= wdata[2];
      end
      if (mode_we) begin
        rbd_q <= wdata[5];
        fs_q  <= wdata[2];
        it_q  <= wdata[1:0];
      end
      rdata_q <= rdata_d;
    end
  end

  assign rdata      = rdata_q;
  assign locked     = lock_q;
  assign enable     = en_q;
  assign free_run   = fr_q;
  assign fast_scale = fs_q;
  assign irq_type   = it_q;
  assign reboot_dis = rbd_q;
endmodule

// File: rtl/wdt_regfront.sv
module wdt_regfront
  import wdt_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [2:0]           cfg_size,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic [CFG_DW-1:0]    cfg_rdata,
  input  logic                 mem_wr,
  input  logic                 mem_rd,
  input  logic [MEM_AW-1:0]    mem_addr,
  input  logic [2:0]           mem_size,
  input  logic [MEM_DW-1:0]    mem_wdata,
  output logic [MEM_DW-1:0]    mem_rdata,
  input  logic                 core_reboot_evt,
  output logic [PRELOAD_W-1:0] preload1,
  output logic [PRELOAD_W-1:0] preload2,
  output logic                 wd_enable,
  output logic                 free_run,
  output logic                 fast_scale,
  output logic [1:0]           irq_type,
  output logic                 reboot_en,
  output logic                 ping,
  output logic                 flag_clr
);
  logic rst_meta, rst_n_s;
  logic grant, cfg_locked, reboot_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  wdt_guard_seq u_guard (
    .clk(clk), .rst_n(rst_n_s), .wr(mem_wr), .addr(mem_addr),
    .size(mem_size), .wdata(mem_wdata), .grant(grant)
  );

  wdt_mem_regs u_mem (
    .clk(clk), .rst_n(rst_n_s), .grant(grant), .rd(mem_rd),
    .addr(mem_addr), .size(mem_size), .wdata(mem_wdata),
    .reboot_evt(core_reboot_evt), .preload1(preload1), .preload2(preload2),
    .ping(ping), .flag_clr(flag_clr), .rdata(mem_rdata)
  );

  wdt_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr(cfg_wr), .rd(cfg_rd),
    .addr(cfg_addr), .size(cfg_size), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .locked(cfg_locked), .enable(wd_enable), .free_run(free_run),
    .fast_scale(fast_scale), .irq_type(irq_type), .reboot_dis(reboot_dis)
  );

  assign reboot_en = !reboot_dis;
endmodule

// File: rtl/wdt_regfront_chk.sv
module wdt_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_wr,
  input logic        mem_rd,
  input logic        cfg_rd,
  input logic [3:0]  mem_addr,
  input logic [2:0]  mem_size,
  input logic [31:0] mem_rdata,
  input logic [15:0] cfg_rdata,
  input logic [19:0] preload1,
  input logic [19:0] preload2,
  input logic        ping,
  input logic        flag_clr,
  input logic        locked,
  input logic        wd_enable,
  input logic        free_run
);
  assert_ping_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ping |=> !ping);
  assert_clr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_clr);
  assert_pre1_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(preload1) |-> $past(mem_wr && mem_size == 3'd4 && mem_addr == 4'h0));
  assert_pre2_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(preload2) |-> $past(mem_wr && mem_size == 3'd4 && mem_addr == 4'h4));
  assert_byte_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_size == 3'd1) |=> ($stable(preload1) && $stable(preload2) && !ping));
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(wd_enable) && $stable(free_run)));
  assert_mem_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> (mem_rdata == 32'h0));
  assert_cfg_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> (cfg_rdata == 16'h0));
endmodule

bind wdt_regfront wdt_regfront_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .mem_wr(mem_wr), .mem_rd(mem_rd), .cfg_rd(cfg_rd),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_rdata(mem_rdata),
  .cfg_rdata(cfg_rdata), .preload1(preload1), .preload2(preload2),
  .ping(ping), .flag_clr(flag_clr), .locked(cfg_locked),
  .wd_enable(wd_enable), .free_run(free_run)
);

// File: tb/sim_wdt_regfront.sv
`timescale 1ns/1ps
module sim_wdt_regfront;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_rd, mem_wr, mem_rd, evt;
  logic [7:0] cfg_addr;
  logic [2:0] cfg_size, mem_size;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [3:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [19:0] preload1, preload2;
  logic wd_enable, free_run, fast_scale, reboot_en, ping, flag_clr;
  logic [1:0] irq_type;
  int n_run = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  wdt_regfront u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .core_reboot_evt(evt),
    .preload1(preload1), .preload2(preload2), .wd_enable(wd_enable),
    .free_run(free_run), .fast_scale(fast_scale), .irq_type(irq_type),
    .reboot_en(reboot_en), .ping(ping), .flag_clr(flag_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mw(input logic [3:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = a; mem_size = s; mem_wdata = d;
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic mr(input logic [3:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    mem_rd = 1'b1; mem_addr = a; mem_size = s;
    @(negedge clk);
    d = mem_rdata; mem_rd = 1'b0;
  endtask

  task automatic cw(input logic [7:0] a, input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_size = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cr(input logic [7:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a; cfg_size = s;
    @(negedge clk);
    d = {16'h0, cfg_rdata}; cfg_rd = 1'b0;
  endtask

  task automatic unlock();
    mw(4'hC, 3'd2, 32'h80);
    mw(4'hC, 3'd2, 32'h86);
  endtask

  task automatic t_reset();
    chk(preload1 == 20'hFFFFF && preload2 == 20'hFFFFF, "R1 preloads", preload1, 20'hFFFFF);
    chk(!wd_enable && !free_run && !fast_scale && irq_type == 0 && reboot_en && !ping && !flag_clr,
        "R1 levels", {wd_enable, free_run, fast_scale, irq_type, reboot_en, ping, flag_clr}, 32'h4);
    cr(8'h68, 3'd1, rv); chk(rv == 0, "R1 lock reg", rv, 0);
    cr(8'h60, 3'd2, rv); chk(rv == 0, "R1 mode reg", rv, 0);
    mr(4'hC, 3'd2, rv);  chk(rv == 0, "R1 flag", rv, 0);
  endtask

  task automatic t_preload();
    unlock(); mw(4'h0, 3'd4, 32'hABC12345);
    chk(preload1 == 20'h12345, "R2 R4 preload1 load", preload1, 20'h12345);
    unlock(); mw(4'h4, 3'd4, 32'hFFF00007);
    chk(preload2 == 20'h00007, "R4 preload2 load", preload2, 20'h7);
    mw(4'h0, 3'd4, 32'h111);
    chk(preload1 == 20'h12345, "R3 one write per unlock", preload1, 20'h12345);
  endtask

  task automatic t_bad_seq();
    mw(4'hC, 3'd2, 32'h86); mw(4'h0, 3'd4, 32'h222);
    chk(preload1 == 20'h12345, "R2 lone 0x86", preload1, 20'h12345);
    mw(4'hC, 3'd2, 32'h80); mw(4'h0, 3'd4, 32'h222); mw(4'hC, 3'd2, 32'h86);
    mw(4'h0, 3'd4, 32'h333);
    chk(preload1 == 20'h12345, "R8 broken sequence", preload1, 20'h12345);
  endtask

  task automatic t_byte();
    unlock(); mw(4'h0, 3'd1, 32'h55);
    chk(preload1 == 20'h12345, "R7 byte write no load", preload1, 20'h12345);
    mw(4'h0, 3'd4, 32'h00444);
    chk(preload1 == 20'h00444, "R7 byte keeps guard open", preload1, 20'h444);
    mw(4'hC, 3'd1, 32'h80); mw(4'hC, 3'd1, 32'h86); mw(4'h4, 3'd4, 32'h555);
    chk(preload2 == 20'h00555, "R7 byte magic sequence", preload2, 20'h555);
    mw(4'h4, 3'd3, 32'h999);
    chk(preload2 == 20'h00555, "R11 bad size ignored", preload2, 20'h555);
  endtask

  task automatic t_ping();
    unlock();
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = 4'hC; mem_size = 3'd2; mem_wdata = 32'h0100;
    @(negedge clk); mem_wr = 1'b0;
    chk(ping && !flag_clr, "R5 ping raised", {ping, flag_clr}, 32'h2);
    @(negedge clk);
    chk(!ping, "R12 ping one cycle", ping, 0);
  endtask

  task automatic t_flag();
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    mr(4'hC, 3'd2, rv); chk(rv == 32'h1200, "R6 flag read", rv, 32'h1200);
    mr(4'hC, 3'd4, rv); chk(rv == 0, "R11 wrong-size read", rv, 0);
    unlock();
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = 4'hC; mem_size = 3'd2; mem_wdata = 32'h0200;
    @(negedge clk); mem_wr = 1'b0;
    chk(flag_clr && !ping, "R6 flag_clr raised", {ping, flag_clr}, 32'h1);
    @(negedge clk);
    chk(!flag_clr, "R12 flag_clr one cycle", flag_clr, 0);
    mr(4'hC, 3'd2, rv); chk(rv == 0, "R6 cleared by bit9", rv, 0);
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    unlock(); mw(4'hC, 3'd2, 32'h1000);
    mr(4'hC, 3'd2, rv); chk(rv == 0, "R6 cleared by bit12", rv, 0);
  endtask

  task automatic t_mode();
    cw(8'h60, 3'd2, 16'h0026);
    chk(!reboot_en && fast_scale && irq_type == 2'd2, "R10 mode levels",
        {reboot_en, fast_scale, irq_type}, 32'h6);
    cr(8'h60, 3'd2, rv); chk(rv == 32'h26, "R10 mode readback", rv, 32'h26);
    cw(8'h60, 3'd1, 16'h0000);
    cr(8'h60, 3'd2, rv); chk(rv == 32'h26, "R11 mode wrong size", rv, 32'h26);
  endtask

  task automatic t_lock();
    cw(8'h68, 3'd1, 16'h06);
    chk(wd_enable && free_run, "R9 enable and free-run", {wd_enable, free_run}, 32'h3);
    cr(8'h68, 3'd1, rv); chk(rv == 32'h6, "R9 lock readback", rv, 32'h6);
    cw(8'h68, 3'd1, 16'h07); cw(8'h68, 3'd1, 16'h00);
    chk(wd_enable && free_run, "R9 locked freeze", {wd_enable, free_run}, 32'h3);
    cr(8'h68, 3'd1, rv); chk(rv == 32'h7, "R9 locked readback", rv, 32'h7);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; mem_wr = 0; mem_rd = 0; evt = 0;
    cfg_addr = 0; cfg_size = 0; cfg_wdata = 0; mem_addr = 0; mem_size = 0; mem_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_preload();
    t_bad_seq();
    t_byte();
    t_ping();
    t_flag();
    t_mode();
    t_lock();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule